// File: doc/BRIEF.md
# Configurable Output Macrocell

This block models the output stage that sits between the AND-OR array of a programmable logic device and one of its I/O pins. It takes the array's sum-of-products term and two dedicated control terms: one clears the storage flip-flop at once, and the other presets it on the next clock edge. Two configuration bits decide how the sum term reaches the pin.

One bit selects the path. Either the sum term drives the pin directly, or the sum term is captured in a D flip-flop on the rising clock edge and the flip-flop drives the pin. The other bit selects the polarity of the pin: true or inverted. That gives four operating modes.

The block also returns a feedback signal to the array. In registered operation the feedback is the flip-flop's true output. In combinational operation the feedback is the level on the pin. That level is the block's own drive when the output enable is high, and the externally applied level when the output enable is low.

Top module: `pld_macrocell`

## Requirements
- R1: With `path_comb`=1 and `pol_true`=1 (combinational, active-high), `pin_out` equals `sum_term` in the same cycle, with no clock edge in between.
- R2: With `path_comb`=1 and `pol_true`=0 (combinational, active-low), `pin_out` equals the inverse of `sum_term` in the same cycle.
- R3: With `path_comb`=0 and `pol_true`=1 (registered, active-high), the flip-flop loads `sum_term` on each rising edge of `clk`, and `pin_out` shows the flip-flop's true output. A change of `sum_term` between edges does not reach `pin_out`.
- R4: With `path_comb`=0 and `pol_true`=0 (registered, active-low), `pin_out` shows the inverse of the flip-flop output.
- R5: When `set_term` is high at a rising edge and `clr_term` is low, the flip-flop becomes 1 whatever the value of `sum_term`.
- R6: While `clr_term` is high, the flip-flop is 0 without waiting for a clock edge. This holds even when `set_term` is high at a rising edge.
- R7: With `path_comb`=0, `fb_out` equals the flip-flop's true output. It is unaffected by `oe_term` and `pin_in`.
- R8: With `path_comb`=1 and `oe_term`=1, `fb_out` equals `pin_out`, and `pin_in` is ignored.
- R9: `pin_en` follows `oe_term`; `pin_en`=0 means the pin is high impedance. With `path_comb`=1 and `oe_term`=0, `fb_out` equals `pin_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Flip-flop clock, rising edge |
| sum_term | input | 1 | Sum-of-products term from the array |
| clr_term | input | 1 | Asynchronous clear term, active high |
| set_term | input | 1 | Synchronous preset term, active high |
| path_comb | input | 1 | 1 = combinational path, 0 = registered path |
| pol_true | input | 1 | 1 = active-high pin, 0 = active-low pin |
| oe_term | input | 1 | Output-enable term |
| pin_in | input | 1 | Level applied to the pin from outside |
| pin_out | output | 1 | Value driven onto the pin |
| pin_en | output | 1 | Pin driver enable; 0 = high impedance |
| fb_out | output | 1 | Feedback to the array |

## Verification
The bench sweeps all four combinations of path and polarity, with the output enable both on and off. A swapped decode of the two configuration bits would show up as an inverted or wrong-path pin value. Feedback is checked with an externally driven pin level that disagrees with the block's own drive. A design that took feedback from the wrong source would therefore return the wrong level in one of the two paths.

The register corner cases are covered directly. A sum-term change between edges must not leak through in registered mode. Preset must win over the sum term. Clear must act before any edge and must beat a simultaneous preset. A synchronous clear, or preset taking priority, would leave a 1 where the bench expects 0.

// File: rtl/pld_macrocell.sv
module pld_macrocell (
  input  logic clk,
  input  logic sum_term,
  input  logic clr_term,
  input  logic set_term,
  input  logic path_comb,
  input  logic pol_true,
  input  logic oe_term,
  input  logic pin_in,
  output logic pin_out,
  output logic pin_en,
  output logic fb_out
);

  logic q;
  logic pin_level;

  always_ff @(posedge clk or posedge clr_term) begin
    if (clr_term)      q <= 1'b0;
    else if (set_term) q <= 1'b1;
    else               q <= sum_term;
  end

  always_comb begin
    unique case ({path_comb, pol_true})
      2'b00: pin_out = ~q;
      2'b01: pin_out = q;
      2'b10: pin_out = ~sum_term;
      2'b11: pin_out = sum_term;
      default: pin_out = 1'b0;
    endcase
  end

  assign pin_en    = oe_term;
  assign pin_level = oe_term ? pin_out : pin_in;
  assign fb_out    = path_comb ? pin_level : q;

endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk (
  input logic clk,
  input logic sum_term,
  input logic clr_term,
  input logic set_term,
  input logic path_comb,
  input logic pol_true,
  input logic oe_term,
  input logic pin_in,
  input logic pin_out,
  input logic pin_en,
  input logic fb_out,
  input logic q
);

  p_load_r3: assert property (@(posedge clk) disable iff (clr_term)
    !set_term |=> q == $past(sum_term));

  p_preset_r5: assert property (@(posedge clk) disable iff (clr_term)
    set_term |=> q);

  p_clear_r6: assert property (@(posedge clk)
    clr_term |-> !q);

  p_reg_pin_r4: assert property (@(posedge clk) disable iff (clr_term)
    (!path_comb && !pol_true) |-> pin_out != fb_out);

  p_reg_fb_r7: assert property (@(posedge clk) disable iff (clr_term)
    !path_comb |-> fb_out == q);

  p_comb_fb_r8: assert property (@(posedge clk) disable iff (clr_term)
    (path_comb && oe_term) |-> fb_out == pin_out);

  p_pin_fb_r9: assert property (@(posedge clk) disable iff (clr_term)
    (path_comb && !pin_en) |-> fb_out == pin_in);

endmodule

bind pld_macrocell pld_macrocell_chk u_chk (
  .clk(clk), .sum_term(sum_term), .clr_term(clr_term), .set_term(set_term),
  .path_comb(path_comb), .pol_true(pol_true), .oe_term(oe_term),
  .pin_in(pin_in), .pin_out(pin_out), .pin_en(pin_en), .fb_out(fb_out),
  .q(q)
);

// File: tb/pld_macrocell_test.sv
`timescale 1ns/1ps
module pld_macrocell_test;
  logic clk = 1'b0;
  logic sum_term = 1'b0, clr_term = 1'b1, set_term = 1'b0;
  logic path_comb = 1'b0, pol_true = 1'b0, oe_term = 1'b1, pin_in = 1'b0;
  logic pin_out, pin_en, fb_out;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pld_macrocell uut (
    .clk(clk), .sum_term(sum_term), .clr_term(clr_term), .set_term(set_term),
    .path_comb(path_comb), .pol_true(pol_true), .oe_term(oe_term),
    .pin_in(pin_in), .pin_out(pin_out), .pin_en(pin_en), .fb_out(fb_out)
  );

  // {path_comb, pol_true, oe, sum, pin_in, exp_out, exp_en, exp_fb}
  localparam logic [7:0] VEC [8] = '{
    8'b11100010, 8'b11110111, 8'b10100111, 8'b10111010,
    8'b11010100, 8'b11001001, 8'b10011001, 8'b10000100
  };

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic to_neg();
    @(negedge clk);
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #20000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // reset state, registered active-low: q=0 -> pin 1, fb 0 (R6, R4)
    repeat (2) to_neg();
    #1;
    check("R6 reset fb", fb_out, 1'b0);
    check("R4 reset pin", pin_out, 1'b1);
    pol_true = 1'b1; #1;
    check("R3 reset pin true", pin_out, 1'b0);

    // combinational table (R1, R2, R8, R9)
    for (int i = 0; i < 8; i++) begin
      to_neg();
      {path_comb, pol_true, oe_term, sum_term, pin_in} = VEC[i][7:3];
      #1;
      check(VEC[i][6] ? "R1 pin" : "R2 pin", pin_out, VEC[i][2]);
      check("R9 en", pin_en, VEC[i][1]);
      check(VEC[i][5] ? "R8 fb" : "R9 fb", fb_out, VEC[i][0]);
    end

    // registered active-high (R3)
    to_neg();
    clr_term = 1'b0; path_comb = 1'b0; pol_true = 1'b1; oe_term = 1'b1;
    sum_term = 1'b0;
    after_edge();
    to_neg();
    sum_term = 1'b1; #1;
    check("R3 no leak before edge", pin_out, 1'b0);
    after_edge();
    check("R3 load", pin_out, 1'b1);
    check("R7 fb reg", fb_out, 1'b1);

    // feedback ignores pin in registered mode (R7)
    to_neg();
    oe_term = 1'b0; pin_in = 1'b0; #1;
    check("R7 fb oe off", fb_out, 1'b1);
    check("R9 en off", pin_en, 1'b0);
    oe_term = 1'b1;

    // preset beats sum (R5)
    sum_term = 1'b0; set_term = 1'b1;
    after_edge();
    check("R5 preset", pin_out, 1'b1);
    to_neg();
    set_term = 1'b0;
    after_edge();
    check("R3 load 0", pin_out, 1'b0);

    // active-low registered (R4)
    to_neg();
    pol_true = 1'b0; #1;
    check("R4 pin q0", pin_out, 1'b1);
    sum_term = 1'b1;
    after_edge();
    check("R4 pin q1", pin_out, 1'b0);
    check("R7 fb q1", fb_out, 1'b1);

    // asynchronous clear beats preset (R6)
    to_neg();
    set_term = 1'b1; clr_term = 1'b1; #1;
    check("R6 async", fb_out, 1'b0);
    after_edge();
    check("R6 over preset", fb_out, 1'b0);
    check("R6 pin", pin_out, 1'b1);
    to_neg();
    clr_term = 1'b0; set_term = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule